// File: doc/BRIEF.md
# Serial attenuator programmer

This block drives the three-wire serial control port of a six-bit step attenuator from a fast system clock. A host presents a six-bit attenuation word and pulses a start strobe. The block then shifts the word out most significant bit first: the 16 dB weight comes first and the 0.5 dB weight comes last. It makes one serial clock rise per bit. After the last falling edge it raises the latch-enable line, holds it high for a minimum width and drops it, which transfers the word into the attenuator.

Every waveform interval is a cycle count derived by rounding up from the system clock period. The intervals are the high phase, the low phase, the data setup before a rise, the data hold after a fall, the latch delay, the latch width and the refresh spacing. After each latch the block waits out a minimum update interval before it accepts the next word. A strobe that arrives while a word is in flight, or during that wait, is remembered and served afterwards. If several strobes arrive in that time, only the most recent word is sent.

The state machine has seven states:
- IDLE waits for a request.
- SETUP holds the serial clock low with the new bit on the data line.
- HIGH holds the serial clock high.
- HOLD keeps the old bit steady after a falling edge.
- LEDLY waits before the latch.
- LATCH holds latch-enable high.
- GAP enforces the update interval.

The transitions are:
- IDLE→SETUP when a request is taken, which loads the word.
- SETUP→HIGH when the setup time expires.
- HIGH→HOLD when the high time expires and bits remain.
- HIGH→LEDLY when the high time expires after the last bit.
- HOLD→SETUP when the hold time expires, which advances to the next bit.
- LEDLY→LATCH, LATCH→GAP and GAP→IDLE, each when its timer expires.

Top module: `atten_ser_prog`

## Requirements
- R1: While reset is high and in the first cycle after it, ser_clk, ser_data, latch_en, busy and done are all 0.
- R2: Each word produces exactly six ser_clk rises. The value of ser_data at the k-th rise is bit (6-k) of the word, so bit 5 goes first and bit 0 goes last.
- R3: With the default 10 ns system clock, ser_clk stays high for 5 cycles per bit. Between two rises of the same word it stays low for 5 cycles, as a 1-cycle hold plus a 4-cycle setup.
- R4: ser_data stays constant while ser_clk is high and in the first low cycle after each fall. A new bit appears 4 cycles before the following rise.
- R5: latch_en is 0 whenever ser_clk is 1. latch_en rises 1 cycle after the last fall of ser_clk, which leaves one full low cycle in between.
- R6: latch_en stays high for exactly 3 cycles, then returns to 0.
- R7: done is 1 for exactly one cycle, the first cycle in which latch_en is 0 again after being high.
- R8: After latch_en falls, the block stays busy for 4000 cycles (40 µs) before it can take a new word. No latch_en rise occurs within 4000 cycles of the previous fall.
- R9: A start pulse seen while busy is 1 is held and served once the block is idle. Only the code from the latest start before service is sent. A start pulse in the same cycle that a held request is served replaces the held code.
- R10: A start taken while idle makes busy 1 from the next cycle. busy stays 1 until the update interval ends, and busy is 1 whenever ser_clk or latch_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| code | input | 6 | Attenuation word to send |
| start | input | 1 | One-cycle request strobe |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_clk | output | 1 | Serial clock, idles low |
| latch_en | output | 1 | Latch enable, pulsed high after shifting |
| busy | output | 1 | High while a word or the update interval is in progress |
| done | output | 1 | One-cycle pulse after the latch closes |

## Verification
Two functions can meet in one cycle. The first is the service of a held request as the update interval ends. The second is the arrival of a fresh start strobe. The bench provokes this by queuing a word during the interval, waiting for busy to drop, and pulsing start with a different word in that first idle cycle. The cycle-level reference model requires the fresh word, not the held one, to be shifted and latched. A separate monitor reassembles the bits captured at each ser_clk rise and confirms that only that word is latched.

// File: rtl/atten_pkg.sv
package atten_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_HOLD,
        ST_LEDLY,
        ST_LATCH,
        ST_GAP
    } atten_st_e;

    // Cycles needed to cover t_ps, rounded up, never below one
    function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/atten_tmr.sv
module atten_tmr #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/atten_shreg.sv
module atten_shreg #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb,
    output logic         last
);
    localparam int unsigned LW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  sh;
    logic [LW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            left <= '0;
        end else if (load) begin
            sh   <= din;
            left <= LW'(W - 1);
        end else if (shift) begin
            sh   <= {sh[W-2:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign msb  = sh[W-1];
    assign last = (left == '0);
endmodule

// File: rtl/atten_req.sv
module atten_req #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] code,
    input  logic         take,
    output logic         req_valid,
    output logic [W-1:0] req_code
);
    logic         pend;
    logic [W-1:0] pend_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_code <= '0;
        end else begin
            if (take)
                pend <= 1'b0;
            else if (start)
                pend <= 1'b1;
            if (start)
                pend_code <= code;
        end
    end

    // A fresh strobe overrides a held code (R9)
    assign req_valid = pend | start;
    assign req_code  = start ? code : pend_code;
endmodule

// File: rtl/atten_ser_prog.sv
module atten_ser_prog
    import atten_pkg::*;
#(
    parameter int unsigned CODE_W        = 6,
    parameter int unsigned CLK_PS        = 10000,
    parameter int unsigned SCLK_PER_PS   = 100000,
    parameter int unsigned PHASE_MIN_PS  = 30000,
    parameter int unsigned SETUP_PS      = 10000,
    parameter int unsigned HOLD_PS       = 10000,
    parameter int unsigned LE_DELAY_PS   = 10000,
    parameter int unsigned LE_WIDTH_PS   = 30000,
    parameter int unsigned UPDATE_PS     = 40000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              start,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              latch_en,
    output logic              busy,
    output logic              done
);
    localparam int unsigned HALF_CYC  = umax(cyc_ceil(PHASE_MIN_PS, CLK_PS),
                                             cyc_ceil(SCLK_PER_PS / 2, CLK_PS));
    localparam int unsigned SETUP_CYC = cyc_ceil(SETUP_PS, CLK_PS);
    localparam int unsigned HOLD_CYC  = cyc_ceil(HOLD_PS, CLK_PS);
    localparam int unsigned LOWB_CYC  = umax(SETUP_CYC,
                                             (HALF_CYC > HOLD_CYC) ? HALF_CYC - HOLD_CYC : 1);
    localparam int unsigned LEDLY_CYC = umax(cyc_ceil(LE_DELAY_PS, CLK_PS), HOLD_CYC);
    localparam int unsigned LEW_CYC   = cyc_ceil(LE_WIDTH_PS, CLK_PS);
    localparam int unsigned GAP_CYC   = cyc_ceil(UPDATE_PS, CLK_PS);
    localparam int unsigned MAX_CYC   = umax(umax(GAP_CYC, LOWB_CYC),
                                             umax(umax(HALF_CYC, LEW_CYC), umax(HOLD_CYC, LEDLY_CYC)));
    localparam int unsigned TMR_W     = $clog2(MAX_CYC + 1);

    atten_st_e          state, state_n;
    logic               tmr_exp, tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               sh_load, sh_shift, sh_msb, sh_last;
    logic               req_valid;
    logic [CODE_W-1:0]  req_code;

    atten_req #(.W(CODE_W)) u_req (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .code      (code),
        .take      (sh_load),
        .req_valid (req_valid),
        .req_code  (req_code)
    );

    atten_shreg #(.W(CODE_W)) u_shreg (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .shift (sh_shift),
        .din   (req_code),
        .msb   (sh_msb),
        .last  (sh_last)
    );

    atten_tmr #(.W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .val     (tmr_val),
        .expired (tmr_exp)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_n;
    end

    // Next state, shift control and timer reload
    always_comb begin
        state_n  = state;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_n = ST_SETUP;
                    sh_load = 1'b1;
                end
            end
            ST_SETUP: if (tmr_exp) state_n = ST_HIGH;
            ST_HIGH:  if (tmr_exp) state_n = sh_last ? ST_LEDLY : ST_HOLD;
            ST_HOLD: begin
                if (tmr_exp) begin
                    state_n  = ST_SETUP;
                    sh_shift = 1'b1;
                end
            end
            ST_LEDLY: if (tmr_exp) state_n = ST_LATCH;
            ST_LATCH: if (tmr_exp) state_n = ST_GAP;
            ST_GAP:   if (tmr_exp) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase

        tmr_load = (state_n != state);
        unique case (state_n)
            ST_SETUP: tmr_val = TMR_W'(LOWB_CYC - 1);
            ST_HIGH:  tmr_val = TMR_W'(HALF_CYC - 1);
            ST_HOLD:  tmr_val = TMR_W'(HOLD_CYC - 1);
            ST_LEDLY: tmr_val = TMR_W'(LEDLY_CYC - 1);
            ST_LATCH: tmr_val = TMR_W'(LEW_CYC - 1);
            ST_GAP:   tmr_val = TMR_W'(GAP_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            ser_clk  <= 1'b0;
            latch_en <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            ser_clk  <= (state_n == ST_HIGH);
            latch_en <= (state_n == ST_LATCH);
            busy     <= (state_n != ST_IDLE);
            done     <= (state == ST_LATCH) && (state_n == ST_GAP);
        end
    end

    assign ser_data = sh_msb;
endmodule

// File: rtl/atten_ser_prog_chk.sv
module atten_ser_prog_chk #(
    parameter int unsigned HALF_CYC  = 5,
    parameter int unsigned LEDLY_CYC = 1,
    parameter int unsigned LEW_CYC   = 3,
    parameter int unsigned GAP_CYC   = 4000
) (
    input logic clk,
    input logic rst,
    input logic ser_data,
    input logic ser_clk,
    input logic latch_en,
    input logic busy,
    input logic done
);
    logic [15:0] hi_len, lo_len, le_len;
    logic [31:0] gap_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len  <= '0;
            lo_len  <= '1;
            le_len  <= '0;
            gap_len <= '1;
        end else begin
            hi_len  <= ser_clk  ? hi_len + 1'b1 : '0;
            lo_len  <= ser_clk  ? '0 : ((lo_len == '1) ? lo_len : lo_len + 1'b1);
            le_len  <= latch_en ? le_len + 1'b1 : '0;
            gap_len <= latch_en ? '0 : ((gap_len == '1) ? gap_len : gap_len + 1'b1);
        end
    end

    p_high_min_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_clk) |-> hi_len >= 16'(HALF_CYC));
    p_low_min_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> lo_len >= 16'(HALF_CYC));
    p_data_high_r4: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_data));
    p_data_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_clk) |-> $stable(ser_data));
    p_le_excl_r5: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> !latch_en);
    p_le_delay_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_en) |-> lo_len >= 16'(LEDLY_CYC));
    p_le_width_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_en) |-> le_len == 16'(LEW_CYC));
    p_done_fell_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_en) |-> done);
    p_done_only_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !latch_en && $past(latch_en));
    p_gap_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_en) |-> gap_len >= 32'(GAP_CYC));
    p_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (ser_clk || latch_en || done) |-> busy);
endmodule

bind atten_ser_prog atten_ser_prog_chk #(
    .HALF_CYC  (HALF_CYC),
    .LEDLY_CYC (LEDLY_CYC),
    .LEW_CYC   (LEW_CYC),
    .GAP_CYC   (GAP_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_data (ser_data),
    .ser_clk  (ser_clk),
    .latch_en (latch_en),
    .busy     (busy),
    .done     (done)
);

// File: tb/test_atten_ser_prog.sv
module test_atten_ser_prog;
    // Timing derived from the requirements at a 10 ns clock
    localparam int T_HIGH  = 5;    // 50 ns high phase
    localparam int T_HOLD  = 1;    // 10 ns hold after fall
    localparam int T_SETUP = 4;    // rest of the 50 ns low phase
    localparam int T_LEDLY = 1;
    localparam int T_LEW   = 3;
    localparam int T_GAP   = 4000; // 40 us

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] code = '0;
    logic       start = 1'b0;
    logic       ser_data, ser_clk, latch_en, busy, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    atten_ser_prog i_atten_ser_prog (
        .clk(clk), .rst(rst), .code(code), .start(start),
        .ser_data(ser_data), .ser_clk(ser_clk), .latch_en(latch_en),
        .busy(busy), .done(done)
    );

    // Reference model: expected {busy, sclk, sdata, le, done} per cycle
    logic [4:0] exp_q[$];
    logic [5:0] lat_q[$];
    logic [4:0] cur = '0;
    logic       m_pend = 1'b0;
    logic [5:0] m_pcode = '0;
    logic       m_last = 1'b0;

    task automatic push_n(input int n, input logic [4:0] v);
        for (int k = 0; k < n; k++) exp_q.push_back(v);
    endtask

    task automatic build(input logic [5:0] c);
        for (int i = 5; i >= 0; i--) begin
            if (i < 5) push_n(T_HOLD, {1'b1, 1'b0, c[i+1], 2'b00});
            push_n(T_SETUP, {1'b1, 1'b0, c[i], 2'b00});
            push_n(T_HIGH,  {1'b1, 1'b1, c[i], 2'b00});
        end
        push_n(T_LEDLY, {1'b1, 1'b0, c[0], 2'b00});
        push_n(T_LEW,   {1'b1, 1'b0, c[0], 2'b10});
        push_n(1,       {1'b1, 1'b0, c[0], 2'b01});
        push_n(T_GAP-1, {1'b1, 1'b0, c[0], 2'b00});
        lat_q.push_back(c);
        m_last = c[0];
    endtask

    always @(posedge clk) begin
        if (rst) begin
            exp_q.delete(); lat_q.delete();
            cur = '0; m_pend = 1'b0; m_pcode = '0; m_last = 1'b0;
        end else begin
            if (!cur[4] && (start || m_pend)) begin
                build(start ? code : m_pcode);
                m_pend = 1'b0;
            end else if (start) begin
                m_pend  = 1'b1;
                m_pcode = code;
            end
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            else cur = {3'b000, m_last, 1'b0} >> 0 == 0 ? {2'b00, m_last, 2'b00} : {2'b00, m_last, 2'b00};
        end
    end

    // Per-cycle comparison against the model
    int prints = 0;
    always @(negedge clk) begin
        if (!rst) begin
            logic [4:0] act;
            act = {busy, ser_clk, ser_data, latch_en, done};
            checks++;
            if (act !== cur) begin
                errors++;
                if (prints < 20) begin
                    prints++;
                    if (act[3] !== cur[3]) $display("FAIL R3 ser_clk act=%b exp=%b t=%0t", act[3], cur[3], $time);
                    else if (act[2] !== cur[2]) $display("FAIL R2/R4 ser_data act=%b exp=%b t=%0t", act[2], cur[2], $time);
                    else if (act[1] !== cur[1]) $display("FAIL R5/R6 latch_en act=%b exp=%b t=%0t", act[1], cur[1], $time);
                    else if (act[0] !== cur[0]) $display("FAIL R7 done act=%b exp=%b t=%0t", act[0], cur[0], $time);
                    else $display("FAIL R10 busy act=%b exp=%b t=%0t", act[4], cur[4], $time);
                end
            end
        end
    end

    // Word reassembly, latch width and spacing monitors
    logic       p_sclk = 0, p_le = 0, seen_fall = 0;
    logic [5:0] cap = '0;
    int         nbits = 0, le_w = 0, since_fall = 0;
    always @(negedge clk) begin
        if (rst) begin
            p_sclk = 0; p_le = 0; nbits = 0; le_w = 0; seen_fall = 0; since_fall = 0;
        end else begin
            if (ser_clk && !p_sclk) begin
                cap = {cap[4:0], ser_data};
                nbits++;
            end
            if (latch_en && !p_le && seen_fall) begin
                checks++;
                if (since_fall < T_GAP) begin
                    errors++;
                    $display("FAIL R8 spacing act=%0d exp>=%0d", since_fall, T_GAP);
                end
            end
            if (latch_en) le_w++;
            if (!latch_en) since_fall++;
            if (!latch_en && p_le) begin
                logic [5:0] want;
                want = (lat_q.size() > 0) ? lat_q.pop_front() : 6'bxxxxxx;
                checks += 2;
                if (nbits != 6 || cap !== want) begin
                    errors++;
                    $display("FAIL R2/R9 latched act=%b/%0d exp=%b/6", cap, nbits, want);
                end
                if (le_w != T_LEW) begin
                    errors++;
                    $display("FAIL R6 le width act=%0d exp=%0d", le_w, T_LEW);
                end
                nbits = 0; le_w = 0; since_fall = 1; seen_fall = 1;
            end
            p_sclk = ser_clk;
            p_le   = latch_en;
        end
    end

    task automatic pulse(input logic [5:0] c);
        @(negedge clk);
        start = 1'b1; code = c;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || m_pend || start) @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({ser_clk, ser_data, latch_en, busy, done} !== 5'b0) begin
            errors++;
            $display("FAIL R1 reset act=%b exp=00000", {ser_clk, ser_data, latch_en, busy, done});
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if ({ser_clk, ser_data, latch_en, busy, done} !== 5'b0) begin
            errors++;
            $display("FAIL R1 after reset act=%b exp=00000", {ser_clk, ser_data, latch_en, busy, done});
        end
        // R2, R3: plain words from idle
        pulse(6'b101101); wait_idle();
        pulse(6'b010010); wait_idle();
        // R9: two strobes while busy, latest wins
        pulse(6'b111111);
        repeat (10) @(negedge clk);
        pulse(6'b000001);
        pulse(6'b100000);
        wait_idle();
        // R8/R9: strobe during the update interval
        pulse(6'b011110);
        @(negedge clk);
        while (!done) @(negedge clk);
        repeat (100) @(negedge clk);
        pulse(6'b110011);
        wait_idle();
        // R9 collision: held request and fresh strobe in the first idle cycle
        pulse(6'b000111);
        repeat (20) @(negedge clk);
        pulse(6'b101010);
        @(negedge clk);
        while (busy) @(negedge clk);
        start = 1'b1; code = 6'b010101;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        pulse(6'b000000); wait_idle();
        repeat (10) @(negedge clk);
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end
endmodule